// File: doc/BRIEF.md
# ROM Signature Test Sequencer

This block runs a built-in check of a parallel 8192 x 8 read-only memory. It drives the memory's 13-bit address, its two active-low chip selects and its active-low power-down line. It reads the byte bus once per read cycle and folds each sampled value into a 16-bit multiple-input signature register. At the end of the test the signature is either stored as the reference (learn mode) or compared with the stored reference, and a pass flag is reported with the final signature.

Full-byte mode reads the two ends of the address space. One run counts upward from address zero. A second run counts downward from the all-ones address. Each run has its own configurable length, so a length of 4096 covers the whole array. Single-pin mode compresses one chosen data bit over an upward run from zero. An optional deselect check follows the compression runs. It drives each control line inactive in turn and expects the pulled-up bus to read all ones.

The read cycle length and the sample point are counts of system clocks, set by parameters. The defaults are 200 and 175 clocks, which at 250 MHz give an 800 ns cycle sampled 700 ns in, for a memory access time of 450 ns.

Top module: `romsig_tester`

## Requirements
- R1: After reset and while idle or done, `rom_sel1_n`, `rom_sel2_n` and `rom_pwrdn_n` are 1 and `rom_addr` is 0. After reset `busy`, `done`, `pass` and `signature` are 0.
- R2: During every compression read all three control lines are 0. Each read lasts CYCLE_CLKS clocks. A full-byte test makes 2*RUN_LEN reads, so the control lines are all low for 2*RUN_LEN*CYCLE_CLKS clocks.
- R3: In full-byte mode, RUN_LEN reads are made at addresses 0,1,2,... and then RUN_LEN reads at addresses 0x1FFF,0x1FFE,...; locations outside these two windows have no effect on the result.
- R4: The bus is sampled once per read, on the SAMPLE_CLKS-th rising edge after the edge that drove the read's address.
- R5: The signature register is 16 bits wide and is cleared at the start of each run. Each sample updates it to next = (s<<1) ^ (s[15] ? 0x1281 : 0) ^ d, where d is the data value zero-extended to 16 bits. The final signature is the up-run value XOR the down-run value, or the single run's value in single-pin mode.
- R6: With `learn` set at start, the final signature becomes the reference and `pass` reports only the deselect result. Otherwise `pass` is 1 when the signature equals the reference and no deselect mismatch occurred. The reference resets to 0.
- R7: In single-pin mode, d = bit `bit_sel` of the data bus (bit 0 = least significant bit), over PIN_RUN_LEN upward reads from 0. The other seven bits have no effect.
- R8: With `desel_chk` set, three one-read steps at address 0 follow the runs. In them `rom_sel1_n`, then `rom_sel2_n`, then `rom_pwrdn_n` is alone at 1. A sample other than 0xFF in any step forces `pass` to 0.
- R9: `start` is accepted only while `busy` is 0. The mode inputs are captured at that point, and a `start` during a test has no effect.
- R10: `done` rises at the end of the test and stays high with `pass` and `signature` valid until the next accepted `start`. `busy` and `done` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test (one-clock pulse) |
| learn | input | 1 | Store the result as reference instead of comparing |
| pin_mode | input | 1 | 1 = single-pin mode, 0 = full-byte mode |
| bit_sel | input | 3 | Data bit compressed in single-pin mode |
| desel_chk | input | 1 | Run the deselect checks after compression |
| rom_addr | output | 13 | Memory address |
| rom_sel1_n | output | 1 | First chip select, active low |
| rom_sel2_n | output | 1 | Second chip select, active low |
| rom_pwrdn_n | output | 1 | Power-down/program line, active low |
| rom_data | input | 8 | Memory data bus (pulled up when undriven) |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, results valid |
| pass | output | 1 | Test result |
| signature | output | 16 | Final signature of the last test |

## Verification
The bench corrupts single bytes just inside and just outside both run windows. A sequencer with an off-by-one run length, or a down run that starts at the wrong address, then passes a bad part or fails a good one. It sweeps all eight bits in single-pin mode, corrupting the selected bit and then a neighbour, which catches a wrong bit index. It varies the memory's access latency by one clock on each side of the sample point, so a sample taken a clock early or late changes the result. It also models a memory that ignores each deselect line in turn, pulses `start` in the middle of a test, and times how long each control line is held.

// File: rtl/romsig_pkg.sv
// Package: shared types and constants of the ROM signature tester.
// Assumes the signature register is 16 bits wide with the feedback taps below.
package romsig_pkg;

    // Test phases, in the order a test walks through them.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_UP,
        PH_DOWN,
        PH_PIN,
        PH_DS_SEL1,
        PH_DS_SEL2,
        PH_DS_PWR,
        PH_DONE
    } phase_t;

    localparam int          SIG_W    = 16;
    // Feedback taps for x^16 + x^12 + x^9 + x^7 + 1.
    localparam logic [15:0] SIG_POLY = 16'h1281;

endpackage

// File: rtl/romsig_cycle_timer.sv
// Read-cycle timer: divides the system clock into read cycles of CYCLE_CLKS
// clocks and marks the sample point and the last clock of each cycle.
// Assumes 1 <= SAMPLE_CLKS < CYCLE_CLKS, so sampling and cycle end never coincide.
module romsig_cycle_timer #(
    parameter int CYCLE_CLKS  = 200,
    parameter int SAMPLE_CLKS = 175,
    localparam int CNT_W      = $clog2(CYCLE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sample_stb,
    output logic cycle_end
);

    logic [CNT_W-1:0] cnt_q;

    // Count clocks within the read cycle; held at zero while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(CYCLE_CLKS - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign sample_stb = run && (cnt_q == CNT_W'(SAMPLE_CLKS - 1));
    assign cycle_end  = run && (cnt_q == CNT_W'(CYCLE_CLKS - 1));

    // R2: the counter never leaves the cycle range.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(CYCLE_CLKS));

    // R4: one clock after the sample point the cycle has not yet wrapped.
    p_sample_before_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && run) |=> (cnt_q != '0 || !run));

endmodule

// File: rtl/romsig_misr.sv
// Multiple-input signature register: Galois-form shift with feedback taps,
// with the input word XORed into the low bits on every enabled clock.
// Assumes clr and en are never high together (the controller guarantees it).
module romsig_misr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h1281
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sig
);

    logic [W-1:0] sig_q;

    // Clear at the start of each run, otherwise fold in one sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sig_q <= '0;
        end else if (en) begin
            sig_q <= {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0) ^ din;
        end
    end

    assign sig = sig_q;

    // R5: a clear leaves the register at zero.
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sig_q == '0));

    // R5: without a sample the signature holds.
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(sig_q));

endmodule

// File: rtl/romsig_addr_seq.sv
// Test sequencer: walks the phases of a test, drives the memory address and
// control lines, and flags the run boundaries for the signature datapath.
// Assumes RUN_LEN and PIN_RUN_LEN are at most half the address space and at least 1.
module romsig_addr_seq
    import romsig_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int RUN_LEN     = 512,
    parameter int PIN_RUN_LEN = 256,
    localparam int MAX_LEN    = (RUN_LEN > PIN_RUN_LEN) ? RUN_LEN : PIN_RUN_LEN,
    localparam int RD_W       = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pin_mode,
    input  logic              desel_en,
    input  logic              cycle_end,
    output phase_t            phase,
    output logic [ADDR_W-1:0] addr,
    output logic              run,
    output logic              down_start,
    output logic              finish,
    output logic              sel1_n,
    output logic              sel2_n,
    output logic              pwrdn_n
);

    phase_t            phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [RD_W-1:0]   rd_q;
    logic              desel_q;
    logic              last_run_rd;
    logic              last_pin_rd;
    logic              quiet;

    assign last_run_rd = (rd_q == RD_W'(RUN_LEN - 1));
    assign last_pin_rd = (rd_q == RD_W'(PIN_RUN_LEN - 1));

    // Phase, address and read-count progression, one step per read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            addr_q  <= '0;
            rd_q    <= '0;
            desel_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_DONE: begin
                    if (start) begin
                        desel_q <= desel_en;
                        addr_q  <= '0;
                        rd_q    <= '0;
                        phase_q <= pin_mode ? PH_PIN : PH_UP;
                    end
                end
                PH_UP: begin
                    if (cycle_end) begin
                        if (last_run_rd) begin
                            phase_q <= PH_DOWN;
                            addr_q  <= '1;
                            rd_q    <= '0;
                        end else begin
                            addr_q <= addr_q + ADDR_W'(1);
                            rd_q   <= rd_q + RD_W'(1);
                        end
                    end
                end
                PH_DOWN: begin
                    if (cycle_end) begin
                        if (last_run_rd) begin
                            phase_q <= desel_q ? PH_DS_SEL1 : PH_DONE;
                            addr_q  <= '0;
                            rd_q    <= '0;
                        end else begin
                            addr_q <= addr_q - ADDR_W'(1);
                            rd_q   <= rd_q + RD_W'(1);
                        end
                    end
                end
                PH_PIN: begin
                    if (cycle_end) begin
                        if (last_pin_rd) begin
                            phase_q <= desel_q ? PH_DS_SEL1 : PH_DONE;
                            addr_q  <= '0;
                            rd_q    <= '0;
                        end else begin
                            addr_q <= addr_q + ADDR_W'(1);
                            rd_q   <= rd_q + RD_W'(1);
                        end
                    end
                end
                PH_DS_SEL1: if (cycle_end) phase_q <= PH_DS_SEL2;
                PH_DS_SEL2: if (cycle_end) phase_q <= PH_DS_PWR;
                PH_DS_PWR:  if (cycle_end) phase_q <= PH_DONE;
                default:    phase_q <= PH_IDLE;
            endcase
        end
    end

    // Decode of phase into control lines and run-boundary strobes.
    always_comb begin
        quiet      = (phase_q == PH_IDLE) || (phase_q == PH_DONE);
        run        = !quiet;
        down_start = (phase_q == PH_UP) && cycle_end && last_run_rd;
        finish     = cycle_end && !desel_q &&
                     (((phase_q == PH_DOWN) && last_run_rd) ||
                      ((phase_q == PH_PIN) && last_pin_rd));
        finish     = finish || (cycle_end && (phase_q == PH_DS_PWR));
        sel1_n     = quiet || (phase_q == PH_DS_SEL1);
        sel2_n     = quiet || (phase_q == PH_DS_SEL2);
        pwrdn_n    = quiet || (phase_q == PH_DS_PWR);
    end

    assign phase = phase_q;
    assign addr  = addr_q;

    // R3: within the upward run each read moves one address up.
    p_addr_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_UP && cycle_end && !last_run_rd) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    // R3: within the downward run each read moves one address down.
    p_addr_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DOWN && cycle_end && !last_run_rd) |=> (addr_q == $past(addr_q) - ADDR_W'(1)));

    // R3: the downward run begins at the all-ones address.
    p_down_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        down_start |=> (addr_q == '1 && phase_q == PH_DOWN));

    // R8: any line held inactive during a test means address 0.
    p_desel_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (sel1_n || sel2_n || pwrdn_n)) |-> (addr_q == '0));

    // R8: at most one control line is inactive while testing.
    p_desel_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> $onehot0({sel1_n, sel2_n, pwrdn_n}));

    // R9: a start during a test leaves the phase unchanged.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && !cycle_end) |=> (phase_q == $past(phase_q)));

endmodule

// File: rtl/romsig_tester.sv
// Top of the ROM signature tester: ties the cycle timer, sequencer and
// signature register together, keeps the reference and reports the verdict.
// Assumes rom_data reads all ones when the memory is deselected (pull-ups).
module romsig_tester
    import romsig_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int RUN_LEN     = 512,
    parameter int PIN_RUN_LEN = 256,
    parameter int CYCLE_CLKS  = 200,
    parameter int SAMPLE_CLKS = 175,
    localparam int SEL_W      = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              learn,
    input  logic              pin_mode,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              desel_chk,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_sel1_n,
    output logic              rom_sel2_n,
    output logic              rom_pwrdn_n,
    input  logic [DATA_W-1:0] rom_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [SIG_W-1:0]  signature
);

    phase_t             phase;
    logic               run;
    logic               sample_stb;
    logic               cycle_end;
    logic               down_start;
    logic               finish;
    logic               accept;
    logic               compress;
    logic               ds_phase;
    logic               misr_clr;
    logic               misr_en;
    logic [SIG_W-1:0]   misr_din;
    logic [SIG_W-1:0]   misr_sig;
    logic [SIG_W-1:0]   final_sig;
    logic [SIG_W-1:0]   save_q;
    logic [SIG_W-1:0]   ref_q;
    logic [SIG_W-1:0]   sig_q;
    logic               pass_q;
    logic               learn_q;
    logic [SEL_W-1:0]   sel_q;
    logic               ds_fail_q;

    romsig_cycle_timer #(
        .CYCLE_CLKS  (CYCLE_CLKS),
        .SAMPLE_CLKS (SAMPLE_CLKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sample_stb (sample_stb),
        .cycle_end  (cycle_end)
    );

    romsig_addr_seq #(
        .ADDR_W      (ADDR_W),
        .RUN_LEN     (RUN_LEN),
        .PIN_RUN_LEN (PIN_RUN_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pin_mode   (pin_mode),
        .desel_en   (desel_chk),
        .cycle_end  (cycle_end),
        .phase      (phase),
        .addr       (rom_addr),
        .run        (run),
        .down_start (down_start),
        .finish     (finish),
        .sel1_n     (rom_sel1_n),
        .sel2_n     (rom_sel2_n),
        .pwrdn_n    (rom_pwrdn_n)
    );

    // Data selection and datapath strobes for the signature register.
    always_comb begin
        accept   = start && !run;
        compress = (phase == PH_UP) || (phase == PH_DOWN) || (phase == PH_PIN);
        ds_phase = (phase == PH_DS_SEL1) || (phase == PH_DS_SEL2) || (phase == PH_DS_PWR);
        misr_clr = accept || down_start;
        misr_en  = sample_stb && compress;
        if (phase == PH_PIN) begin
            misr_din = {{(SIG_W-1){1'b0}}, rom_data[sel_q]};
        end else begin
            misr_din = {{(SIG_W-DATA_W){1'b0}}, rom_data};
        end
        final_sig = save_q ^ misr_sig;
    end

    romsig_misr #(
        .W    (SIG_W),
        .POLY (SIG_POLY)
    ) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (misr_clr),
        .en    (misr_en),
        .din   (misr_din),
        .sig   (misr_sig)
    );

    // Capture of the per-test options at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            learn_q <= 1'b0;
            sel_q   <= '0;
        end else if (accept) begin
            learn_q <= learn;
            sel_q   <= bit_sel;
        end
    end

    // Holding of the up-run signature while the down run compresses.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            save_q <= '0;
        end else if (down_start) begin
            save_q <= misr_sig;
        end
    end

    // Deselect mismatch flag: any non-all-ones sample in a deselect step.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            ds_fail_q <= 1'b0;
        end else if (sample_stb && ds_phase && (rom_data != '1)) begin
            ds_fail_q <= 1'b1;
        end
    end

    // Verdict, reported signature and learned reference at end of test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            sig_q  <= '0;
            pass_q <= 1'b0;
        end else if (accept) begin
            pass_q <= 1'b0;
        end else if (finish) begin
            sig_q <= final_sig;
            if (learn_q) begin
                ref_q  <= final_sig;
                pass_q <= !ds_fail_q;
            end else begin
                pass_q <= (final_sig == ref_q) && !ds_fail_q;
            end
        end
    end

    assign busy      = run;
    assign done      = (phase == PH_DONE);
    assign pass      = pass_q;
    assign signature = sig_q;

    // R10: busy and done never overlap.
    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10: done persists until a new start.
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(signature)));

    // R10: pass can only be reported once a test has finished.
    p_pass_when_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    // R5: clearing and folding a sample never happen on the same clock.
    p_clr_en_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(misr_clr && misr_en));

    // R2: every compression sample is taken with the memory fully selected.
    p_sample_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        misr_en |-> (!rom_sel1_n && !rom_sel2_n && !rom_pwrdn_n));

    // R6: in learn mode the reference follows the reported signature.
    p_learn_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && learn_q) |=> (ref_q == signature));

endmodule

// File: tb/tb_romsig_tester.sv
// Bench for romsig_tester: short runs and a fast read cycle, a behavioural
// memory with pull-ups, latency and stuck-select faults, and signatures
// computed arithmetically from the requirements.
module tb_romsig_tester;

    localparam int CYC = 4;
    localparam int SMP = 3;
    localparam int L   = 16;
    localparam int PL  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        learn = 1'b0;
    logic        pin_mode = 1'b0;
    logic [2:0]  bit_sel = 3'd0;
    logic        desel_chk = 1'b0;
    logic [12:0] rom_addr;
    logic        rom_sel1_n, rom_sel2_n, rom_pwrdn_n;
    logic [7:0]  rom_data;
    logic        busy, done, pass;
    logic [15:0] signature;

    // Memory model controls.
    logic [12:0] bad_addr = 13'd4000;
    logic [7:0]  bad_mask = 8'h00;
    bit          lat_on = 1'b0;
    int          lat_thr = 0;
    bit          stuck1 = 1'b0, stuck2 = 1'b0, stuckp = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc_n  = 0;

    // Observed control-line activity.
    int rd_clks = 0, ds1_clks = 0, ds2_clks = 0, dsp_clks = 0;
    logic [12:0] prev_addr = '0;
    int          age = 0;

    always #2 clk = ~clk;

    romsig_tester #(
        .RUN_LEN     (L),
        .PIN_RUN_LEN (PL),
        .CYCLE_CLKS  (CYC),
        .SAMPLE_CLKS (SMP)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .learn       (learn),
        .pin_mode    (pin_mode),
        .bit_sel     (bit_sel),
        .desel_chk   (desel_chk),
        .rom_addr    (rom_addr),
        .rom_sel1_n  (rom_sel1_n),
        .rom_sel2_n  (rom_sel2_n),
        .rom_pwrdn_n (rom_pwrdn_n),
        .rom_data    (rom_data),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .signature   (signature)
    );

    function automatic logic [7:0] mem_val(logic [12:0] a);
        logic [7:0] v;
        v = a[7:0] * 8'd37 + {3'b000, a[12:8]} * 8'd11 + 8'd5;
        return v ^ ((a == bad_addr) ? bad_mask : 8'h00);
    endfunction

    // Memory: data after the modelled latency, pull-ups when deselected.
    always_comb begin
        logic sel;
        sel = (stuck1 || !rom_sel1_n) && (stuck2 || !rom_sel2_n) && (stuckp || !rom_pwrdn_n);
        if (!sel)                          rom_data = 8'hFF;
        else if (lat_on && age < lat_thr)  rom_data = 8'h00;
        else                               rom_data = mem_val(rom_addr);
    end

    // Address age and control-line activity counters.
    always @(posedge clk) begin
        prev_addr <= rom_addr;
        age <= (rom_addr != prev_addr) ? 0 : age + 1;
        if (!rom_sel1_n && !rom_sel2_n && !rom_pwrdn_n) rd_clks <= rd_clks + 1;
        if (busy && rom_sel1_n && !rom_sel2_n && !rom_pwrdn_n) ds1_clks <= ds1_clks + 1;
        if (busy && !rom_sel1_n && rom_sel2_n && !rom_pwrdn_n) ds2_clks <= ds2_clks + 1;
        if (busy && !rom_sel1_n && !rom_sel2_n && rom_pwrdn_n) dsp_clks <= dsp_clks + 1;
    end

    function automatic logic [15:0] step(logic [15:0] s, logic [15:0] d);
        return {s[14:0], 1'b0} ^ (s[15] ? 16'h1281 : 16'h0000) ^ d;
    endfunction

    function automatic logic [15:0] exp_sig(bit pin, int sel);
        logic [15:0] s1, s2;
        logic [7:0]  v;
        s1 = '0;
        s2 = '0;
        for (int i = 0; i < (pin ? PL : L); i++) begin
            v  = mem_val(13'(i));
            s1 = step(s1, pin ? {15'd0, v[sel]} : {8'd0, v});
        end
        if (pin) return s1;
        for (int i = 0; i < L; i++) begin
            v  = mem_val(13'(8191 - i));
            s2 = step(s2, {8'd0, v});
        end
        return s1 ^ s2;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        if (cyc_n > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc_n);
            summary();
        end
    end

    task automatic do_run(bit pin, logic [2:0] sel, bit ds, bit lrn, bit poke);
        int n;
        @(negedge clk);
        rd_clks = 0; ds1_clks = 0; ds2_clks = 0; dsp_clks = 0;
        pin_mode = pin; bit_sel = sel; desel_chk = ds; learn = lrn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1; pin_mode = ~pin; learn = 1'b1; desel_chk = ~ds;
            @(negedge clk);
            start = 1'b0; pin_mode = pin; learn = lrn; desel_chk = ds;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R10 done after test", 32'(done), 32'd1);
    endtask

    initial begin
        logic [15:0] full_ref;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk({busy, done, pass} == 3'b000, "R1 flags after reset", 32'({busy, done, pass}), 0);
        chk(signature == 16'h0, "R1 signature after reset", 32'(signature), 0);
        chk({rom_sel1_n, rom_sel2_n, rom_pwrdn_n} == 3'b111 && rom_addr == 0,
            "R1 idle controls", 32'({rom_sel1_n, rom_sel2_n, rom_pwrdn_n, rom_addr}), 32'h7 << 13);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rom_sel1_n, rom_sel2_n, rom_pwrdn_n} == 3'b111, "R1 idle after reset release",
            32'({rom_sel1_n, rom_sel2_n, rom_pwrdn_n}), 7);

        // R5/R6: learn a full-byte signature.
        full_ref = exp_sig(1'b0, 0);
        do_run(1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
        chk(signature == full_ref, "R5 full signature learned", 32'(signature), 32'(full_ref));
        chk(pass == 1'b1, "R6 learn run passes", 32'(pass), 1);
        chk(rd_clks == 2 * L * CYC, "R2 selected clocks full mode", rd_clks, 2 * L * CYC);
        chk(!busy && {rom_sel1_n, rom_sel2_n, rom_pwrdn_n} == 3'b111 && rom_addr == 0,
            "R1 controls when done", 32'({busy, rom_sel1_n, rom_sel2_n, rom_pwrdn_n}), 7);

        // R6: compare against the same memory.
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk(pass == 1'b1 && signature == full_ref, "R6 compare good part", 32'({pass, signature}), 32'({1'b1, full_ref}));

        // R3: corruption at window edges, inside and outside.
        bad_mask = 8'h10;
        bad_addr = 13'h1FFF - 13'd3;
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk(pass == 1'b0, "R3 down window corruption detected", 32'(pass), 0);
        chk(signature == exp_sig(1'b0, 0), "R5 signature of corrupted part", 32'(signature), 32'(exp_sig(1'b0, 0)));
        bad_addr = 13'(L - 1);
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk(pass == 1'b0, "R3 last up address covered", 32'(pass), 0);
        bad_addr = 13'(L);
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk(pass == 1'b1, "R3 first address past up window ignored", 32'(pass), 1);
        bad_addr = 13'h1FFF - 13'(L);
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk(pass == 1'b1, "R3 first address past down window ignored", 32'(pass), 1);
        bad_addr = 13'h1FFF;
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk(pass == 1'b0, "R3 top address covered", 32'(pass), 0);
        bad_mask = 8'h00;

        // R7: single-pin mode over every bit.
        for (int b = 0; b < 8; b++) begin
            bad_mask = 8'h00;
            do_run(1'b1, 3'(b), 1'b0, 1'b1, 1'b0);
            chk(signature == exp_sig(1'b1, b), "R7 pin signature", 32'(signature), 32'(exp_sig(1'b1, b)));
            chk(rd_clks == PL * CYC, "R7 pin run length", rd_clks, PL * CYC);
            bad_addr = 13'd2;
            bad_mask = 8'(1 << ((b + 1) % 8));
            do_run(1'b1, 3'(b), 1'b0, 1'b0, 1'b0);
            chk(pass == 1'b1, "R7 other bit ignored", 32'(pass), 1);
            bad_mask = 8'(1 << b);
            do_run(1'b1, 3'(b), 1'b0, 1'b0, 1'b0);
            chk(pass == 1'b0, "R7 selected bit detected", 32'(pass), 0);
            chk(signature == exp_sig(1'b1, b), "R7 corrupted pin signature", 32'(signature), 32'(exp_sig(1'b1, b)));
        end
        bad_mask = 8'h00;

        // R8: deselect steps with a good part, then each line stuck.
        do_run(1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
        do_run(1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
        chk(pass == 1'b1, "R8 deselect good part", 32'(pass), 1);
        chk(ds1_clks == CYC && ds2_clks == CYC && dsp_clks == CYC, "R8 step lengths",
            32'(ds1_clks + ds2_clks + dsp_clks), 3 * CYC);
        stuck1 = 1'b1;
        do_run(1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
        chk(pass == 1'b0, "R8 first select ignored by memory", 32'(pass), 0);
        stuck1 = 1'b0; stuck2 = 1'b1;
        do_run(1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
        chk(pass == 1'b0, "R8 second select ignored by memory", 32'(pass), 0);
        stuck2 = 1'b0; stuckp = 1'b1;
        do_run(1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
        chk(pass == 1'b0, "R8 power-down ignored by memory", 32'(pass), 0);
        stuckp = 1'b0;
        do_run(1'b0, 3'd0, 1'b1, 1'b1, 1'b0);
        chk(pass == 1'b1 && signature == full_ref, "R6 learn with deselect", 32'(pass), 1);

        // R4: sample point bracketed by memory latency.
        lat_on = 1'b1; lat_thr = SMP - 2;
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk(pass == 1'b1, "R4 data ready one clock before sample", 32'(pass), 1);
        lat_thr = SMP - 1;
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk(pass == 1'b0, "R4 data ready one clock after sample", 32'(pass), 0);
        lat_on = 1'b0;

        // R9: start during a test has no effect.
        do_run(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
        chk(pass == 1'b1 && signature == full_ref, "R9 mid-test start ignored", 32'({pass, signature}), 32'({1'b1, full_ref}));
        chk(rd_clks == 2 * L * CYC, "R9 run length unchanged", rd_clks, 2 * L * CYC);

        // R10: results held until next start.
        repeat (50) @(negedge clk);
        chk(done && !busy && pass && signature == full_ref, "R10 results held", 32'({done, busy, pass}), 32'h5);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && busy && !pass, "R10 new start clears done", 32'({done, busy, pass}), 32'h2);

        summary();
    end

endmodule